// File: doc/BRIEF.md
# 64-bit Integer Add/Subtract Unit with Carry, Overflow and Condition Flags

This unit is the adder stage of a fixed-point execution pipeline. Each cycle that `inValid` is high, it takes two register operands, a 16-bit immediate, an operation code and the current carry and overflow state. It then produces a registered result one clock later. The supported operations are:

- plain add;
- subtract-from, which computes the second operand minus the first;
- add with carry-in;
- add with carry-in plus all ones, which decrements the operand unless a carry comes in;
- add with carry-in only;
- add of a sign-extended immediate shifted up by sixteen bits.

For the shifted-immediate form, a zero source-register field makes the first operand read as a literal zero rather than as the register value.

Alongside the result, the unit returns the updated carry pair {CA32, CA}, the overflow pair {OV32, OV} and the sticky summary-overflow bit SO. When the record bit is set, it also returns a 4-bit condition field that classifies the result as negative, positive or zero, with SO folded into its lowest bit. Decode, the register file and writeback lie outside the unit. The source operands are inputs only and are never altered.

Top module: `intAddUnit`

## Requirements
- R1: A high `inValid` at a rising clock edge makes `outValid` high for exactly the following cycle. With `inValid` low, `outValid` goes low, and `result`, `caOut`, `ovOut`, `soOut` and `crOut` hold their last values.
- R2: `opSel` 0 computes opA+opB. `opSel` 1 computes opB−opA, formed as ~opA+opB+1. Codes 6 and 7 behave exactly like code 0. All results are taken modulo 2^64.
- R3: `opSel` 2 computes opA+opB+CA. `opSel` 3 computes opA+CA+0xFFFF_FFFF_FFFF_FFFF. `opSel` 4 computes opA+CA. CA is `caIn[0]`.
- R4: `opSel` 5 computes A'+(sign-extended imm16 shifted left by 16), where A' is zero when `raIsZero` is 1 and is opA otherwise.
- R5: For `opSel` 2, 3 and 4, `caOut` = {carry out of bit 31, carry out of bit 63} of the addition, including the carry-in. For all other codes, `caOut` equals `caIn`.
- R6: When `ovEnable` is 1 and `opSel` is not 5, `ovOut` = {signed 32-bit overflow, signed 64-bit overflow} of the addition. Otherwise `ovOut` equals `ovIn`.
- R7: `soOut` = `soIn` OR (the 64-bit overflow bit computed under R6), so SO is set by overflow and never cleared by the unit.
- R8: `crValid` is high together with `outValid` only when the operation had `recordEn` = 1. `crOut` bit 3 means the result is negative, bit 2 means positive and nonzero, bit 1 means zero, and bit 0 equals `soOut`.
- R9: After reset, `outValid`, `crValid`, `result`, `caOut`, `ovOut`, `soOut` and `crOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Operation code (see R2 to R4) |
| recordEn | input | 1 | Produce the condition field |
| ovEnable | input | 1 | Overflow-recording form |
| raIsZero | input | 1 | Source field is zero (shifted-immediate form) |
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand |
| imm16 | input | 16 | Signed immediate |
| caIn | input | 2 | Incoming {CA32, CA} |
| ovIn | input | 2 | Incoming {OV32, OV} |
| soIn | input | 1 | Incoming summary overflow |
| outValid | output | 1 | Result valid |
| result | output | 64 | Sum |
| caOut | output | 2 | Updated {CA32, CA} |
| ovOut | output | 2 | Updated {OV32, OV} |
| soOut | output | 1 | Updated summary overflow |
| crOut | output | 4 | Condition field {neg, pos, zero, SO} |
| crValid | output | 1 | Condition field valid |

## Verification
The only state in the unit is its output register and the valid flags. Any wrong control decode therefore appears at the ports on the cycle after the strobe: a wrong carry-in selection or operand inversion shows up as an off-by-one or complemented sum. An incorrect split of the carry chain shows up as a bad CA32 on operands chosen to carry out of bit 31. A bad load enable shows up as outputs that drift during idle cycles. Each of these is visible one cycle after the offending operation and is checked there.

// File: rtl/intAddPkg.sv
package intAddPkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD   = 3'd0;
  localparam logic [OP_W-1:0] OP_SUBF  = 3'd1;
  localparam logic [OP_W-1:0] OP_ADDE  = 3'd2;
  localparam logic [OP_W-1:0] OP_ADDME = 3'd3;
  localparam logic [OP_W-1:0] OP_ADDZE = 3'd4;
  localparam logic [OP_W-1:0] OP_ADDIS = 3'd5;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_CARRY = 2'd2
  } cinSel_e;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_IMM  = 2'd1,
    BSRC_ONES = 2'd2,
    BSRC_ZERO = 2'd3
  } bSrc_e;

  typedef struct packed {
    logic    load;
    logic    zeroA;
    logic    invA;
    bSrc_e   bSrc;
    cinSel_e cinSel;
    logic    writeCa;
    logic    ovCheck;
  } addCtrl_t;

endpackage

// File: rtl/intAddCtrl.sv
module intAddCtrl
  import intAddPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  input  logic            recordEn,
  input  logic            ovEnable,
  input  logic            raIsZero,
  output addCtrl_t        ctrl,
  output logic            outValid,
  output logic            crValid
);

  addCtrl_t dec;

  always_comb begin
    dec = '0;
    dec.load = inValid;
    dec.bSrc = BSRC_REG;
    dec.cinSel = CIN_ZERO;
    dec.ovCheck = ovEnable;
    case (opSel)
      OP_SUBF: begin
        dec.invA = 1'b1;
        dec.cinSel = CIN_ONE;
      end
      OP_ADDE: begin
        dec.cinSel = CIN_CARRY;
        dec.writeCa = 1'b1;
      end
      OP_ADDME: begin
        dec.bSrc = BSRC_ONES;
        dec.cinSel = CIN_CARRY;
        dec.writeCa = 1'b1;
      end
      OP_ADDZE: begin
        dec.bSrc = BSRC_ZERO;
        dec.cinSel = CIN_CARRY;
        dec.writeCa = 1'b1;
      end
      OP_ADDIS: begin
        dec.bSrc = BSRC_IMM;
        dec.zeroA = raIsZero;
        dec.ovCheck = 1'b0;
      end
      default: begin
        dec.bSrc = BSRC_REG;
      end
    endcase
  end

  assign ctrl = dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      crValid <= 1'b0;
    end else begin
      outValid <= inValid;
      crValid <= inValid & recordEn;
    end
  end

endmodule

// File: rtl/intAddDatapath.sv
module intAddDatapath
  import intAddPkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned IMMW = IMM_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  addCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMMW-1:0]  imm16,
  input  logic [1:0]       caIn,
  input  logic [1:0]       ovIn,
  input  logic             soIn,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       caOut,
  output logic [1:0]       ovOut,
  output logic             soOut,
  output logic [3:0]       crOut
);

  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned EXT_W = WIDTH - IMMW - IMMW;

  logic [WIDTH-1:0] aEff, xOp, yOp, immExt, sum;
  logic [HALF:0]    loSum, hiSum;
  logic             cin, carry32, carry64, ovf32, ovf64;
  logic [1:0]       nextCa, nextOv;
  logic             nextSo, isNeg, isZero;
  logic [3:0]       nextCr;

  assign immExt = {{EXT_W{imm16[IMMW-1]}}, imm16, {IMMW{1'b0}}};

  always_comb begin
    aEff = ctrl.zeroA ? '0 : opA;
    xOp = ctrl.invA ? ~aEff : aEff;
    case (ctrl.bSrc)
      BSRC_IMM:  yOp = immExt;
      BSRC_ONES: yOp = '1;
      BSRC_ZERO: yOp = '0;
      default:   yOp = opB;
    endcase
    case (ctrl.cinSel)
      CIN_ONE:   cin = 1'b1;
      CIN_CARRY: cin = caIn[0];
      default:   cin = 1'b0;
    endcase
  end

  // Two half-width adders chained so the mid-point carry is explicit.
  always_comb begin
    loSum = {1'b0, xOp[HALF-1:0]} + {1'b0, yOp[HALF-1:0]} + {{HALF{1'b0}}, cin};
    hiSum = {1'b0, xOp[WIDTH-1:HALF]} + {1'b0, yOp[WIDTH-1:HALF]}
          + {{HALF{1'b0}}, loSum[HALF]};
    sum = {hiSum[HALF-1:0], loSum[HALF-1:0]};
    carry32 = loSum[HALF];
    carry64 = hiSum[HALF];
  end

  always_comb begin
    ovf64 = (xOp[WIDTH-1] == yOp[WIDTH-1]) && (sum[WIDTH-1] != xOp[WIDTH-1]);
    ovf32 = (xOp[HALF-1] == yOp[HALF-1]) && (sum[HALF-1] != xOp[HALF-1]);
    nextCa = ctrl.writeCa ? {carry32, carry64} : caIn;
    nextOv = ctrl.ovCheck ? {ovf32, ovf64} : ovIn;
    nextSo = soIn | (ctrl.ovCheck & ovf64);
    isNeg = sum[WIDTH-1];
    isZero = (sum == '0);
    nextCr = {isNeg, ~isNeg & ~isZero, isZero, nextSo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      caOut <= '0;
      ovOut <= '0;
      soOut <= 1'b0;
      crOut <= '0;
    end else if (ctrl.load) begin
      result <= sum;
      caOut <= nextCa;
      ovOut <= nextOv;
      soOut <= nextSo;
      crOut <= nextCr;
    end
  end

endmodule

// File: rtl/intAddUnit.sv
module intAddUnit
  import intAddPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opSel,
  input  logic        recordEn,
  input  logic        ovEnable,
  input  logic        raIsZero,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [15:0] imm16,
  input  logic [1:0]  caIn,
  input  logic [1:0]  ovIn,
  input  logic        soIn,
  output logic        outValid,
  output logic [63:0] result,
  output logic [1:0]  caOut,
  output logic [1:0]  ovOut,
  output logic        soOut,
  output logic [3:0]  crOut,
  output logic        crValid
);

  addCtrl_t ctrl;

  intAddCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .recordEn(recordEn), .ovEnable(ovEnable), .raIsZero(raIsZero),
    .ctrl(ctrl), .outValid(outValid), .crValid(crValid)
  );

  intAddDatapath #(.WIDTH(DATA_W), .IMMW(IMM_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .imm16(imm16), .caIn(caIn), .ovIn(ovIn), .soIn(soIn),
    .result(result), .caOut(caOut), .ovOut(ovOut), .soOut(soOut),
    .crOut(crOut)
  );

endmodule

// File: rtl/intAddChk.sv
module intAddChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  opSel,
  input logic        recordEn,
  input logic        ovEnable,
  input logic        raIsZero,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [15:0] imm16,
  input logic [1:0]  caIn,
  input logic [1:0]  ovIn,
  input logic        soIn,
  input logic        outValid,
  input logic [63:0] result,
  input logic [1:0]  caOut,
  input logic [1:0]  ovOut,
  input logic        soOut,
  input logic [3:0]  crOut,
  input logic        crValid
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(crOut) && $stable(caOut)));

  // R5
  carry_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == 3'd0 || opSel == 3'd1 || opSel == 3'd5)) |=> (caOut == $past(caIn)));

  // R6
  ov_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ovEnable) |=> (ovOut == $past(ovIn)));

  // R7
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && soIn) |=> soOut);

  // R4
  imm_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd5 && raIsZero) |=> (result[15:0] == 16'h0));

  // R8
  cr_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    crValid |-> ($countones(crOut[3:1]) == 1 && crOut[1] == (result == 64'h0)));

  // R8
  cr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    crValid |-> outValid);

endmodule

bind intAddUnit intAddChk i_chk (.*);

// File: tb/test_intAddUnit.sv
`timescale 1ns/1ps
module test_intAddUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic        recordEn = 1'b0, ovEnable = 1'b0, raIsZero = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [15:0] imm16 = '0;
  logic [1:0]  caIn = '0, ovIn = '0;
  logic        soIn = 1'b0;
  logic        outValid, soOut, crValid;
  logic [63:0] result;
  logic [1:0]  caOut, ovOut;
  logic [3:0]  crOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intAddUnit i_intAddUnit (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refCalc(
    input logic [2:0] op, input logic ovE, input logic raZ,
    input logic [63:0] a, input logic [63:0] b, input logic [15:0] imm,
    input logic [1:0] ca, input logic [1:0] ov, input logic so,
    output logic [63:0] r, output logic [1:0] caR, output logic [1:0] ovR,
    output logic soR, output logic [3:0] cr);
    logic [63:0] x, y;
    logic c;
    logic [64:0] s65, t65;
    logic [32:0] s33, t33;
    x = (op == 3'd5 && raZ) ? 64'h0 : a;
    y = b;
    c = 1'b0;
    case (op)
      3'd1: begin x = ~a; c = 1'b1; end
      3'd2: c = ca[0];
      3'd3: begin y = '1; c = ca[0]; end
      3'd4: begin y = '0; c = ca[0]; end
      3'd5: y = 64'($signed(imm)) << 16;
      default: ;
    endcase
    s65 = {1'b0, x} + {1'b0, y} + 65'(c);
    s33 = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(c);
    t65 = {x[63], x} + {y[63], y} + 65'(c);
    t33 = {x[31], x[31:0]} + {y[31], y[31:0]} + 33'(c);
    r = s65[63:0];
    caR = (op == 3'd2 || op == 3'd3 || op == 3'd4) ? {s33[32], s65[64]} : ca;
    if (ovE && op != 3'd5) begin
      ovR = {t33[32] ^ t33[31], t65[64] ^ t65[63]};
      soR = so | (t65[64] ^ t65[63]);
    end else begin
      ovR = ov;
      soR = so;
    end
    if (r[63]) cr = {3'b100, soR};
    else if (r == 0) cr = {3'b001, soR};
    else cr = {3'b010, soR};
  endfunction

  // Drive at a falling edge, sample at the next falling edge.
  task automatic runOp(input string tag, input logic [2:0] op, input logic rec,
                       input logic ovE, input logic raZ, input logic [63:0] a,
                       input logic [63:0] b, input logic [15:0] imm,
                       input logic [1:0] ca, input logic [1:0] ov, input logic so,
                       input logic checkHold);
    logic [63:0] er;
    logic [1:0] eca, eov;
    logic eso;
    logic [3:0] ecr;
    refCalc(op, ovE, raZ, a, b, imm, ca, ov, so, er, eca, eov, eso, ecr);
    inValid = 1'b1; opSel = op; recordEn = rec; ovEnable = ovE; raIsZero = raZ;
    opA = a; opB = b; imm16 = imm; caIn = ca; ovIn = ov; soIn = so;
    @(negedge clk);
    inValid = 1'b0;
    opA = ~a; opB = ~b; caIn = ~ca; ovIn = ~ov; soIn = ~so;
    chk({tag, " R1 outValid"}, 64'(outValid), 64'h1);
    chk({tag, " R2/R3/R4 result"}, result, er);
    chk({tag, " R5 caOut"}, 64'(caOut), 64'(eca));
    chk({tag, " R6 ovOut"}, 64'(ovOut), 64'(eov));
    chk({tag, " R7 soOut"}, 64'(soOut), 64'(eso));
    chk({tag, " R8 crValid"}, 64'(crValid), 64'(rec));
    if (rec) chk({tag, " R8 crOut"}, 64'(crOut), 64'(ecr));
    if (checkHold) begin
      @(negedge clk);
      chk({tag, " R1 idle outValid"}, 64'(outValid), 64'h0);
      chk({tag, " R1 idle result hold"}, result, er);
      chk({tag, " R1 idle flags hold"}, 64'({caOut, ovOut, soOut}), 64'({eca, eov, eso}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 outValid", 64'(outValid), 64'h0);
    chk("R9 crValid", 64'(crValid), 64'h0);
    chk("R9 result", result, 64'h0);
    chk("R9 flags", 64'({caOut, ovOut, soOut, crOut}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 directed add with record, literal expectation
    runOp("add rec", 3'd0, 1'b1, 1'b0, 1'b0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8,
          16'h0, 2'b00, 2'b00, 1'b0, 1'b1);
    chk("R2 literal add", result, 64'ha709a363416426bd);
    chk("R8 literal cr neg", 64'(crOut), 64'h8);
    // R2 subf
    runOp("subf", 3'd1, 1'b0, 1'b0, 1'b0, 64'h3d7f3f7ca24bac7b, 64'hf6b2ac5e13ee15c2,
          16'h0, 2'b00, 2'b00, 1'b0, 1'b1);
    chk("R2 literal subf", result, 64'hb9336ce171a26947);
    runOp("subf neg", 3'd1, 1'b1, 1'b0, 1'b0, 64'h10, 64'h5, 16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    chk("R2 literal subf neg", result, 64'hfffffffffffffff5);
    // R2 reserved codes act as add
    runOp("op6", 3'd6, 1'b0, 1'b0, 1'b0, 64'h2e08ae202742baf8, 64'h86c43ece9efe5baa,
          16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    chk("R2 literal op6 add", result, 64'hb4cceceec64116a2);
    runOp("op7", 3'd7, 1'b0, 1'b1, 1'b0, 64'h1, 64'h2, 16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    // R3 / R5 addme
    runOp("addme ca0", 3'd3, 1'b1, 1'b0, 1'b0, 64'h7ffffffff, 64'h0, 16'h0, 2'b00, 2'b00, 1'b0, 1'b1);
    chk("R3 literal addme ca0", result, 64'h7fffffffe);
    chk("R5 literal addme carry", 64'(caOut), 64'h3);
    chk("R8 literal addme cr", 64'(crOut), 64'h4);
    runOp("addme ca1", 3'd3, 1'b1, 1'b1, 1'b0, 64'hffff80000, 64'h0, 16'h0, 2'b01, 2'b00, 1'b0, 1'b0);
    chk("R3 literal addme ca1", result, 64'hffff80000);
    runOp("addme zero", 3'd3, 1'b1, 1'b1, 1'b0, 64'h0, 64'h0, 16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    // R7 / R8 SO folded in without ovEnable
    runOp("addme so", 3'd3, 1'b1, 1'b0, 1'b0, 64'h7ffffffff, 64'h0, 16'h0, 2'b01, 2'b00, 1'b1, 1'b1);
    chk("R8 literal cr with SO", 64'(crOut), 64'h5);
    // R3 addze, adde
    runOp("addze", 3'd4, 1'b1, 1'b1, 1'b0, 64'h00ff00ff00ff0080, 64'h5, 16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    runOp("addze wrap", 3'd4, 1'b1, 1'b1, 1'b0, 64'hffffffffffffffff, 64'h0, 16'h0, 2'b01, 2'b00, 1'b0, 1'b0);
    chk("R3 literal addze wrap", result, 64'h0);
    chk("R5 literal addze wrap carry", 64'(caOut), 64'h3);
    runOp("adde", 3'd2, 1'b1, 1'b1, 1'b0, 64'h00000000ffffffff, 64'h0, 16'h0, 2'b01, 2'b00, 1'b0, 1'b0);
    chk("R5 literal adde ca32 only", 64'(caOut), 64'h2);
    // R4 addis
    runOp("addis raz", 3'd5, 1'b0, 1'b1, 1'b1, 64'h5, 64'h0, 16'h0001, 2'b10, 2'b11, 1'b0, 1'b1);
    chk("R4 literal addis zero RA", result, 64'h10000);
    chk("R6 literal addis ov held", 64'(ovOut), 64'h3);
    runOp("addis neg", 3'd5, 1'b1, 1'b0, 1'b1, 64'h1234, 64'h0, 16'h8000, 2'b00, 2'b00, 1'b0, 1'b0);
    chk("R4 literal addis neg", result, 64'hffffffff80000000);
    runOp("addis reg", 3'd5, 1'b0, 1'b0, 1'b0, 64'h1234, 64'h0, 16'h0002, 2'b00, 2'b00, 1'b0, 1'b0);
    chk("R4 literal addis reg", result, 64'h21234);
    // R6 / R7 overflow
    runOp("ovf64", 3'd0, 1'b1, 1'b1, 1'b0, 64'h7fffffffffffffff, 64'h1, 16'h0, 2'b00, 2'b00, 1'b0, 1'b1);
    chk("R6 literal ov64", 64'(ovOut), 64'h1);
    chk("R7 literal so set", 64'(soOut), 64'h1);
    runOp("ovf32", 3'd0, 1'b0, 1'b1, 1'b0, 64'h7fffffff, 64'h1, 16'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    chk("R6 literal ov32 only", 64'({ovOut, soOut}), 64'h4);
    runOp("ov cleared", 3'd0, 1'b0, 1'b1, 1'b0, 64'h1, 64'h1, 16'h0, 2'b00, 2'b11, 1'b1, 1'b0);
    chk("R7 literal so kept", 64'({ovOut, soOut}), 64'h1);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      logic [2:0] op;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      op = 3'($urandom_range(0, 7));
      if (i % 7 == 0) ra[62:0] = '1;
      if (i % 11 == 0) rb = ~ra;
      runOp("random", op, 1'($urandom), 1'($urandom), 1'($urandom), ra, rb,
            16'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), (i % 5 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule